// File: doc/BRIEF.md
# Address-Region Bus Wait-State Generator

This block sits between a CPU bus controller and external memory and decides, for every bus access, how long the bus master must hold. It maps the 20-bit access address onto one of eight regions of a 1 MB space. The first 64 KB is split into four equal 16 KB slices. Above that, the regions double in size: 64 KB, 128 KB, 256 KB and 512 KB. Each region owns a 2-bit wait code. A code asks for no wait, one wait cycle, two wait cycles, or a hold that lasts while an external active-low WAIT pin stays asserted.

The eight codes live in two control registers on a small write port. One is an 8-bit register that software can read and write; it holds the four low-memory regions. The other is a 16-bit register that software can only write; its low byte holds the four upper regions and its high byte is a constant. Accesses that fall inside a parameterised on-chip peripheral RAM window never wait, whatever their region code says. The block's only bus-side output is `ready_o`. When that output is low, the master keeps the current access.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset every region uses code 10 (two waits), a read at the low register address returns AAh, and `ready_o` is high while no access is pending.
- R2: When an access starts with strobe high and the block idle, and its region code is 00, `ready_o` stays high in the strobe cycle.
- R3: Code 01 drives `ready_o` low for exactly one cycle, the strobe cycle, and it is high in the following cycle.
- R4: Code 10 drives `ready_o` low for exactly two cycles: the strobe cycle and the one after it.
- R5: Code 11 keeps `ready_o` low from the strobe cycle on. The WAIT pin passes through a two-flop synchronizer, and `ready_o` returns high on the cycle after the synchronized WAIT is seen high. With WAIT already high the hold is two cycles. If WAIT rises before clock edge k (counting the strobe edge as edge 0), the hold is k+3 cycles.
- R6: Region select: addresses below 10000h use address bits [15:14] as the region number 0..3. Otherwise the highest set bit among bits 16..19 picks regions 4..7 (bit 16 gives 4, bit 19 gives 7).
- R7: Any access whose address lies within the peripheral RAM window (default 0FD00h to 0FEFFh inclusive) keeps `ready_o` high, whatever its code.
- R8: A register write takes effect from the next clock edge. An access strobed in the same cycle as the write uses the old code, and a write during a hold does not change the length of that hold.
- R9: Writing the low register (address 0FFC7h) stores data bits [7:0], with region n in bits [2n+1:2n]. Writing the high register (address 0FFC8h) stores data bits [7:0], with region 4+n in bits [2n+1:2n]. Data bits [15:8] of a high-register write have no effect. A read at any address other than the low register returns 00h.
- R10: A strobe that arrives while a hold is in progress is ignored: it neither extends nor restarts the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_stb_i | input | 1 | Access start strobe, one cycle per access |
| acc_addr_i | input | 20 | Address of the access being started |
| reg_wr_i | input | 1 | Control register write enable |
| reg_addr_i | input | 20 | Control register address for write and read |
| reg_wdata_i | input | 16 | Control register write data |
| reg_rdata_o | output | 8 | Low register contents when reg_addr_i selects it, else zero |
| wait_ni | input | 1 | External active-low WAIT pin, asynchronous |
| ready_o | output | 1 | High when the current access may complete |

## Verification
`ready_o` responds in the same cycle as the strobe, because it is combinational on the strobe and the decoded code. The fixed-wait codes then keep it low for one or two cycles in total. In external-wait mode, a WAIT rise before edge k shows as ready at the negative edge after edge k+2, because it passes two synchronizer flops and the state register. The bench drives inputs on the falling edge, samples one time unit later, and counts the low samples from the strobe cycle until ready is seen high. This counts every register on the path, so each count compares directly with the cycle numbers in the requirements. Register reads are combinational and are sampled in the same half-cycle as the address. Register writes are checked by the length of the next access.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        WC_NONE = 2'b00,
        WC_ONE  = 2'b01,
        WC_TWO  = 2'b10,
        WC_EXT  = 2'b11
    } wcode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_COUNT = 2'b01,
        SQ_EXT   = 2'b10
    } sq_state_e;

    localparam logic [CODE_W-1:0] RESET_CODE = WC_TWO;

endpackage

// File: rtl/bwg_ctrl_regs.sv
module bwg_ctrl_regs
    import bwg_pkg::*;
#(
    parameter int                ADDR_W  = 20,
    parameter int                NUM_LO  = 4,
    parameter int                NUM_HI  = 4,
    parameter logic [ADDR_W-1:0] LO_ADDR = 20'h0FFC7,
    parameter logic [ADDR_W-1:0] HI_ADDR = 20'h0FFC8,
    parameter int                DATA_W  = 16
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [NUM_LO*CODE_W-1:0]            rdata_o,
    output logic [(NUM_LO+NUM_HI)*CODE_W-1:0]   codes_o
);

    localparam int LO_W  = NUM_LO * CODE_W;
    localparam int HI_FW = NUM_HI * CODE_W;

    typedef struct packed {
        logic [LO_W-1:0]  lo;
        logic [HI_FW-1:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;

    // next-state: the fixed upper byte of the wide register has no storage
    always_comb begin
        regs_d = regs_q;
        if (wr_i && (addr_i == LO_ADDR)) begin
            regs_d.lo = wdata_i[LO_W-1:0];
        end
        if (wr_i && (addr_i == HI_ADDR)) begin
            regs_d.hi = wdata_i[HI_FW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.lo <= {NUM_LO{RESET_CODE}};
            regs_q.hi <= {NUM_HI{RESET_CODE}};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = (addr_i == LO_ADDR) ? regs_q.lo : '0;

    // per-region code fan-out
    for (genvar g = 0; g < NUM_LO; g++) begin : g_lo_field
        assign codes_o[g*CODE_W +: CODE_W] = regs_q.lo[g*CODE_W +: CODE_W];
    end
    for (genvar g = 0; g < NUM_HI; g++) begin : g_hi_field
        assign codes_o[(NUM_LO+g)*CODE_W +: CODE_W] = regs_q.hi[g*CODE_W +: CODE_W];
    end

endmodule

// File: rtl/bwg_addr_decode.sv
module bwg_addr_decode #(
    parameter int                ADDR_W   = 20,
    parameter int                NUM_LO   = 4,
    parameter int                LOW_SPAN = 16,
    parameter int                IDX_W    = 3,
    parameter logic [ADDR_W-1:0] PRAM_LO  = 20'h0FD00,
    parameter logic [ADDR_W-1:0] PRAM_HI  = 20'h0FEFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  region_o,
    output logic              exempt_o
);

    localparam int LSEL_W = $clog2(NUM_LO);

    // low slices by top bits of the low span, then highest set upper bit
    always_comb begin
        region_o = IDX_W'(addr_i[LOW_SPAN-1 -: LSEL_W]);
        for (int b = LOW_SPAN; b < ADDR_W; b++) begin
            if (addr_i[b]) begin
                region_o = IDX_W'(NUM_LO + b - LOW_SPAN);
            end
        end
    end

    assign exempt_o = (addr_i >= PRAM_LO) && (addr_i <= PRAM_HI);

endmodule

// File: rtl/bwg_wait_sync.sv
module bwg_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/bwg_wait_seq.sv
module bwg_wait_seq
    import bwg_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              exempt_i,
    input  logic              wait_hi_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic              ext_o
);

    typedef struct packed {
        sq_state_e        state;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_wait;

    assign start_wait = stb_i && !exempt_i && (code_i != WC_NONE)
                        && (seq_q.state == SQ_IDLE);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (start_wait) begin
                    if (code_i == WC_EXT) begin
                        seq_d.state = SQ_EXT;
                    end else if (code_i != WC_ONE) begin
                        // strobe cycle is the first wait cycle
                        seq_d.state = SQ_COUNT;
                        seq_d.cnt   = CNT_W'(code_i) - CNT_W'(1);
                    end
                end
            end
            SQ_COUNT: begin
                seq_d.cnt = seq_q.cnt - CNT_W'(1);
                if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.state = SQ_IDLE;
                end
            end
            SQ_EXT: begin
                if (wait_hi_i) begin
                    seq_d.state = SQ_IDLE;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.state <= SQ_IDLE;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.state != SQ_IDLE);
    assign ext_o   = (seq_q.state == SQ_EXT);
    assign ready_o = !busy_o && !start_wait;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter int                ADDR_W      = 20,
    parameter logic [ADDR_W-1:0] LO_REG_ADDR = 20'h0FFC7,
    parameter logic [ADDR_W-1:0] HI_REG_ADDR = 20'h0FFC8,
    parameter logic [ADDR_W-1:0] PRAM_LO     = 20'h0FD00,
    parameter logic [ADDR_W-1:0] PRAM_HI     = 20'h0FEFF,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_stb_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              wait_ni,
    output logic              ready_o
);

    localparam int LOW_SPAN    = 16;
    localparam int NUM_LO      = 4;
    localparam int NUM_HI      = ADDR_W - LOW_SPAN;
    localparam int NUM_REGIONS = NUM_LO + NUM_HI;
    localparam int IDX_W       = $clog2(NUM_REGIONS);
    localparam int CNT_W       = CODE_W;

    logic [NUM_REGIONS*CODE_W-1:0] codes;
    logic [IDX_W-1:0]              region;
    logic [CODE_W-1:0]             cur_code;
    logic                          exempt;
    logic                          wait_hi;
    logic                          seq_busy;
    logic                          seq_ext;

    bwg_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .NUM_LO (NUM_LO),
        .NUM_HI (NUM_HI),
        .LO_ADDR(LO_REG_ADDR),
        .HI_ADDR(HI_REG_ADDR),
        .DATA_W (16)
    ) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .codes_o(codes)
    );

    bwg_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_LO  (NUM_LO),
        .LOW_SPAN(LOW_SPAN),
        .IDX_W   (IDX_W),
        .PRAM_LO (PRAM_LO),
        .PRAM_HI (PRAM_HI)
    ) u_dec (
        .addr_i  (acc_addr_i),
        .region_o(region),
        .exempt_o(exempt)
    );

    assign cur_code = codes[region*CODE_W +: CODE_W];

    bwg_wait_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(wait_ni),
        .sync_o (wait_hi)
    );

    bwg_wait_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (acc_stb_i),
        .code_i   (cur_code),
        .exempt_i (exempt),
        .wait_hi_i(wait_hi),
        .ready_o  (ready_o),
        .busy_o   (seq_busy),
        .ext_o    (seq_ext)
    );

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
    parameter int                ADDR_W      = 20,
    parameter logic [ADDR_W-1:0] LO_REG_ADDR = 20'h0FFC7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              acc_stb_i,
    input logic              ready_o,
    input logic              busy_i,
    input logic              ext_i,
    input logic [1:0]        code_i,
    input logic              exempt_i,
    input logic              wait_hi_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [15:0]       reg_wdata_i,
    input logic [7:0]        reg_rdata_o
);

    logic start;
    assign start = acc_stb_i && !busy_i;

    // R2
    a_r2_zero_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && code_i == 2'b00) |-> ready_o);

    // R7
    a_r7_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && exempt_i) |-> ready_o);

    // R3
    a_r3_one_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && !exempt_i && code_i == 2'b01) |-> (!ready_o ##1 !busy_i));

    // R4
    a_r4_two_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && !exempt_i && code_i == 2'b10) |-> (!ready_o ##1 !ready_o ##1 !busy_i));

    // R5
    a_r5_ext_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_i && !wait_hi_i) |=> !ready_o);

    // R5
    a_r5_ext_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_i && wait_hi_i) |=> !busy_i);

    // R10
    a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && acc_stb_i) |-> !ready_o);

    // R9
    a_r9_lo_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == LO_REG_ADDR) |=>
        (reg_addr_i != LO_REG_ADDR || reg_wr_i || reg_rdata_o == $past(reg_wdata_i[7:0])));

endmodule

bind bus_wait_gen bwg_checker #(
    .ADDR_W     (ADDR_W),
    .LO_REG_ADDR(LO_REG_ADDR)
) u_bwg_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_stb_i  (acc_stb_i),
    .ready_o    (ready_o),
    .busy_i     (seq_busy),
    .ext_i      (seq_ext),
    .code_i     (cur_code),
    .exempt_i   (exempt),
    .wait_hi_i  (wait_hi),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o)
);

// File: tb/test_bus_wait_gen.sv
`timescale 1ns/1ps
module test_bus_wait_gen;

    localparam logic [19:0] LO_A = 20'h0FFC7;
    localparam logic [19:0] HI_A = 20'h0FFC8;
    localparam int NVEC = 14;

    // {lo[7:0], hi[15:0], addr[19:0], expected low cycles[3:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h00, 16'h0000, 20'h00100, 4'd0},
        {8'h01, 16'h0000, 20'h00100, 4'd1},
        {8'h08, 16'h0000, 20'h04000, 4'd2},
        {8'h10, 16'h0000, 20'h0BFFF, 4'd1},
        {8'hC0, 16'h0000, 20'h0C000, 4'd2},
        {8'h00, 16'h0001, 20'h10000, 4'd1},
        {8'h00, 16'h0008, 20'h3FFFF, 4'd2},
        {8'h00, 16'h0010, 20'h40000, 4'd1},
        {8'h00, 16'h0080, 20'hFFFFF, 4'd2},
        {8'h00, 16'h0080, 20'h7FFFF, 4'd0},
        {8'hFF, 16'h0000, 20'h0FD00, 4'd0},
        {8'hFF, 16'h0000, 20'h0FEFF, 4'd0},
        {8'h80, 16'h0000, 20'h0FCFF, 4'd2},
        {8'h80, 16'h0000, 20'h0FF00, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        reg_wr = 1'b0;
    logic [19:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        wait_n = 1'b1;
    logic        ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_wait_gen i_bus_wait_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .acc_stb_i  (acc_stb),
        .acc_addr_i (acc_addr),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .wait_ni    (wait_n),
        .ready_o    (ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // counts cycles with ready low, starting with the strobe cycle
    task automatic run_access(input logic [19:0] a, input int raise_at,
                              input bit poke, output int lows);
        @(negedge clk);
        acc_stb = 1'b1; acc_addr = a;
        #1;
        lows = ready ? 0 : 1;
        for (int i = 1; i < 60; i++) begin
            @(negedge clk);
            acc_stb = 1'b0;
            if (poke && i == 2) begin
                acc_stb = 1'b1; acc_addr = 20'h00000;
            end
            #1;
            if (ready) break;
            lows++;
            if (raise_at == i) wait_n = 1'b1;
        end
        acc_stb = 1'b0;
    endtask

    function automatic string vtag(input int v);
        case (v)
            0, 9:      return "R2 R6 zero wait";
            1, 3, 5, 7: return "R3 R6 one wait";
            4:         return "R5 R6 ext wait high";
            10, 11:    return "R7 exempt window";
            default:   return "R4 R6 two waits";
        endcase
    endfunction

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        reg_addr = LO_A; #1;
        check(reg_rdata == 8'hAA, "R1 low reg reset", reg_rdata, 8'hAA);
        check(ready == 1'b1, "R1 idle ready", ready, 1);
        reg_addr = HI_A; #1;
        check(reg_rdata == 8'h00, "R9 high reg not readable", reg_rdata, 0);
        run_access(20'h00000, 0, 0, lows);
        check(lows == 2, "R1 reset code region 0", lows, 2);
        run_access(20'hFFFFF, 0, 0, lows);
        check(lows == 2, "R1 reset code region 7", lows, 2);

        // table of region / code vectors
        for (int v = 0; v < NVEC; v++) begin
            write_reg(LO_A, {8'h00, VEC[v][47:40]});
            write_reg(HI_A, VEC[v][39:24]);
            run_access(VEC[v][23:4], 0, 0, lows);
            check(lows == int'(VEC[v][3:0]), vtag(v), lows, int'(VEC[v][3:0]));
        end

        // R9 readback and ignored upper byte
        write_reg(LO_A, 16'h005A);
        @(negedge clk); reg_addr = LO_A; #1;
        check(reg_rdata == 8'h5A, "R9 low reg readback", reg_rdata, 8'h5A);
        write_reg(HI_A, 16'hFF00);
        run_access(20'h10000, 0, 0, lows);
        check(lows == 0, "R9 upper byte ignored region 4", lows, 0);
        run_access(20'h80000, 0, 0, lows);
        check(lows == 0, "R9 upper byte ignored region 7", lows, 0);

        // R8 write in strobe cycle uses old code
        write_reg(LO_A, 16'h0000);
        @(negedge clk);
        acc_stb = 1'b1; acc_addr = 20'h00000;
        reg_wr = 1'b1; reg_addr = LO_A; reg_wdata = 16'h0002;
        #1;
        check(ready == 1'b1, "R8 same-cycle write keeps old code", ready, 1);
        @(negedge clk);
        acc_stb = 1'b0; reg_wr = 1'b0;
        run_access(20'h00000, 0, 0, lows);
        check(lows == 2, "R8 new code on next access", lows, 2);

        // R8 write during a hold
        @(negedge clk);
        acc_stb = 1'b1; acc_addr = 20'h00000; #1;
        lows = ready ? 0 : 1;
        @(negedge clk);
        acc_stb = 1'b0; reg_wr = 1'b1; reg_addr = LO_A; reg_wdata = 16'h0000; #1;
        if (!ready) lows++;
        @(negedge clk);
        reg_wr = 1'b0; #1;
        if (!ready) lows++;
        check(lows == 2, "R8 hold unchanged by write", lows, 2);

        // R5 external wait held low, R10 strobe during hold ignored
        write_reg(LO_A, 16'h00C3);
        @(negedge clk); wait_n = 1'b0;
        repeat (3) @(negedge clk);
        run_access(20'h0C000, 5, 1, lows);
        check(lows == 8, "R5 R10 ext hold with late WAIT", lows, 8);
        run_access(20'h00000, 0, 0, lows);
        check(lows == 2, "R5 ext min hold", lows, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule